// File: doc/BRIEF.md
# Serial Shift-Add Neuron

This block is one digital neuron that takes the outputs of the previous layer one value per clock. Every connection has a weight held in a private read-only table inside the neuron. Each weight is limited to zero or to a signed power of two no larger than one in magnitude. Because of that, the product of an input and its weight is an arithmetic right shift of the input, negated when the weight is negative, and no multiplier is needed.

A load strobe places a bias value in the accumulator and starts a new pass. The shifted terms are added to the accumulator one by one, with saturation on every addition. After the last connection, the upper bits of the sum address a computed activation table, which gives an 8-bit result. A one-cycle done flag marks that result. The result then holds until the next pass completes.

A controller that owns a layer pulses the load strobe with the bias, streams the inputs in connection order using the valid flag, and collects the output when done rises.

Top module: `serial_shift_neuron`

## Requirements
- R1: While reset is active and after it is released, `done` and `act_out` are 0 until a pass completes.
- R2: A `load` pulse places `bias`, read as a 12-bit two's complement value, in the accumulator. With every input zero, the result is the activation of the bias alone.
- R3: A weight code has 4 bits. Bit 3 enables the weight (0 means weight zero), bit 2 negates it, and bits 1:0 give the shift k, so the weight is ±2^-k. The default table for connections 0 to 4 is +1/2, -1, +1/8, -1/4, 0.
- R4: The term for an input x is floor(x / 2^k), the arithmetic shift of the signed 8-bit input, and it is negated after the shift when bit 2 is set. No rounding is applied.
- R5: Inputs are taken in arrival order. The n-th accepted input uses the weight of connection n-1, and low cycles of `in_valid` between inputs change nothing.
- R6: `done` is high for exactly one cycle, in the second cycle after the clock edge that accepts the fifth input, and never at any other time.
- R7: Each addition saturates to the 12-bit range -2048..2047 before the next term is added.
- R8: The result is 128 + 4*floor(S/64), clamped to 0..255, where S is the final sum. The table index is the upper 6 bits of S with the sign bit inverted. `act_out` holds this value until the next completed pass.
- R9: A `load` pulse during a pass restarts it. Inputs taken before the restart do not count, and `done` follows only after five more accepted inputs.
- R10: `in_valid` is ignored while no pass is open. `done` stays low and `act_out` does not change.
- R11: When `load` and `in_valid` are high in the same cycle, the load takes effect and that input is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Start strobe; captures the bias and opens a pass |
| bias | input | 12 | Signed bias value, sampled with `load` |
| in_valid | input | 1 | Marks `in_data` as the next connection's input |
| in_data | input | 8 | Signed input from the previous layer |
| done | output | 1 | One-cycle flag for a new result |
| act_out | output | 8 | Activation output, held between passes |

## Verification
The bench uses the default parameters: five connections, 8-bit inputs, shifts up to three, a 12-bit accumulator and a 64-entry table with slope 4. With these values every input value on every connection can be swept, and biases can be stepped through all 64 positions of one table bucket, so a one-LSB rounding or sign error in a term shows up in the output. The 12-bit range is small enough that extreme biases drive the running sum into both saturation limits, where clamping at each step differs visibly from clamping once at the end. Restart, overlap and idle-valid cases are run on the same configuration.

// File: rtl/neuron_pkg.sv
package neuron_pkg;

   typedef enum logic [1:0] {
      NS_IDLE   = 2'd0,
      NS_ACCUM  = 2'd1,
      NS_FINISH = 2'd2
   } nrn_state_e;

   localparam int NRN_OUT_W = 8;

endpackage

// File: rtl/nrn_weight_rom.sv
module nrn_weight_rom #(
   parameter int N_CONN    = 5,
   parameter int SHIFT_MAX = 3,
   parameter int SH_W      = 2,
   parameter int CODE_W    = 4,
   parameter int IDX_W     = 3,
   parameter logic [N_CONN*CODE_W-1:0] WEIGHTS = '0
) (
   input  logic [IDX_W-1:0]  idx,
   output logic [CODE_W-1:0] code
);
   localparam int RI_W = (N_CONN > 1) ? $clog2(N_CONN) : 1;

   logic [CODE_W-1:0] tbl [N_CONN];

   for (genvar e = 0; e < N_CONN; e++) begin : g_entry
      assign tbl[e] = WEIGHTS[e*CODE_W +: CODE_W];
      initial begin
         if (int'(WEIGHTS[e*CODE_W +: SH_W]) > SHIFT_MAX)
            $fatal(1, "weight entry %0d shifts past SHIFT_MAX", e);
      end
   end

   always_comb begin
      if (idx < IDX_W'(N_CONN))
         code = tbl[idx[RI_W-1:0]];
      else
         code = '0;
   end

endmodule

// File: rtl/nrn_shift_term.sv
module nrn_shift_term #(
   parameter int IN_W   = 8,
   parameter int SH_W   = 2,
   parameter int CODE_W = 4,
   parameter int PROD_W = 9,
   parameter int IMPL   = 0
) (
   input  logic [IN_W-1:0]          x,
   input  logic [CODE_W-1:0]        code,
   output logic signed [PROD_W-1:0] term
);
   logic              w_en;
   logic              w_neg;
   logic [SH_W-1:0]   w_sh;
   logic signed [IN_W-1:0]   shifted;
   logic signed [PROD_W-1:0] ext;

   assign w_en  = code[CODE_W-1];
   assign w_neg = code[CODE_W-2];
   assign w_sh  = code[SH_W-1:0];

   if (IMPL == 0) begin : g_barrel
      logic signed [IN_W-1:0] xs;
      assign xs      = $signed(x);
      assign shifted = xs >>> w_sh;
   end else begin : g_staged
      logic signed [IN_W-1:0] stg [SH_W+1];
      assign stg[0] = $signed(x);
      for (genvar s = 0; s < SH_W; s++) begin : g_stage
         assign stg[s+1] = w_sh[s] ? (stg[s] >>> (1 << s)) : stg[s];
      end
      assign shifted = stg[SH_W];
   end

   assign ext = PROD_W'(shifted);

   always_comb begin
      if (!w_en)
         term = '0;
      else if (w_neg)
         term = -ext;
      else
         term = ext;
   end

endmodule

// File: rtl/nrn_sat_acc.sv
module nrn_sat_acc #(
   parameter int PROD_W = 9,
   parameter int ACC_W  = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic [ACC_W-1:0]         bias,
   input  logic                     add_en,
   input  logic signed [PROD_W-1:0] term,
   output logic signed [ACC_W-1:0]  acc
);
   localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

   logic signed [ACC_W:0]   sum_w;
   logic signed [ACC_W-1:0] sum_sat;

   assign sum_w = (ACC_W+1)'(acc) + (ACC_W+1)'(term);

   always_comb begin
      if (sum_w[ACC_W] != sum_w[ACC_W-1])
         sum_sat = sum_w[ACC_W] ? ACC_MIN : ACC_MAX;
      else
         sum_sat = sum_w[ACC_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         acc <= '0;
      else if (load)
         acc <= $signed(bias);
      else if (add_en)
         acc <= sum_sat;
   end

endmodule

// File: rtl/nrn_act_lut.sv
module nrn_act_lut #(
   parameter int ACC_W  = 12,
   parameter int LUT_AW = 6,
   parameter int SLOPE  = 4,
   parameter int OUT_W  = 8
) (
   input  logic signed [ACC_W-1:0] acc,
   output logic [OUT_W-1:0]        act
);
   localparam int DEPTH = 1 << LUT_AW;
   localparam int LOW_W = ACC_W - LUT_AW;

   function automatic logic [OUT_W-1:0] entry_val(input int a);
      int s;
      int v;
      s = a - (1 << (LUT_AW-1));
      v = (1 << (OUT_W-1)) + SLOPE * s;
      if (v < 0) v = 0;
      if (v > (1 << OUT_W) - 1) v = (1 << OUT_W) - 1;
      return OUT_W'(v);
   endfunction

   logic [OUT_W-1:0]  tbl [DEPTH];
   logic [LUT_AW-1:0] addr;

   for (genvar a = 0; a < DEPTH; a++) begin : g_ent
      assign tbl[a] = entry_val(a);
   end

   assign addr = {~acc[ACC_W-1], acc[ACC_W-2 -: LUT_AW-1]};
   assign act  = tbl[addr];

   if (LOW_W > 0) begin : g_low
      logic unused_low;
      assign unused_low = ^acc[LOW_W-1:0];
   end

endmodule

// File: rtl/serial_shift_neuron.sv
module serial_shift_neuron
   import neuron_pkg::*;
#(
   parameter int N_CONN     = 5,
   parameter int IN_W       = 8,
   parameter int SHIFT_MAX  = 3,
   parameter int LUT_AW     = 6,
   parameter int SLOPE      = 4,
   parameter int SHIFT_IMPL = 0,
   localparam int SH_W   = (SHIFT_MAX > 0) ? $clog2(SHIFT_MAX + 1) : 1,
   localparam int CODE_W = SH_W + 2,
   localparam int PROD_W = IN_W + 1,
   localparam int ACC_W  = PROD_W + $clog2(N_CONN),
   localparam int IDX_W  = $clog2(N_CONN + 1),
   parameter logic [N_CONN*CODE_W-1:0] WEIGHTS = 20'b0000_1110_1011_1100_1001
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [ACC_W-1:0]     bias,
   input  logic                 in_valid,
   input  logic [IN_W-1:0]      in_data,
   output logic                 done,
   output logic [NRN_OUT_W-1:0] act_out
);
   initial begin
      if (N_CONN < 2)            $fatal(1, "N_CONN must be at least 2");
      if (IN_W < 2)              $fatal(1, "IN_W must be at least 2");
      if (SHIFT_MAX >= IN_W)     $fatal(1, "SHIFT_MAX must be below IN_W");
      if (LUT_AW < 2)            $fatal(1, "LUT_AW must be at least 2");
      if (LUT_AW > ACC_W)        $fatal(1, "LUT_AW exceeds accumulator width");
      if (SHIFT_IMPL > 1)        $fatal(1, "SHIFT_IMPL selects 0 or 1");
   end

   nrn_state_e               state;
   logic [IDX_W-1:0]         cnt;
   logic                     accum;
   logic                     accept;
   logic [CODE_W-1:0]        w_code;
   logic signed [PROD_W-1:0] term;
   logic signed [ACC_W-1:0]  acc;
   logic [NRN_OUT_W-1:0]     act_val;

   assign accum  = (state == NS_ACCUM);
   assign accept = accum && in_valid && !load;

   nrn_weight_rom #(
      .N_CONN(N_CONN), .SHIFT_MAX(SHIFT_MAX), .SH_W(SH_W),
      .CODE_W(CODE_W), .IDX_W(IDX_W), .WEIGHTS(WEIGHTS)
   ) i_rom (
      .idx (cnt),
      .code(w_code)
   );

   nrn_shift_term #(
      .IN_W(IN_W), .SH_W(SH_W), .CODE_W(CODE_W),
      .PROD_W(PROD_W), .IMPL(SHIFT_IMPL)
   ) i_term (
      .x   (in_data),
      .code(w_code),
      .term(term)
   );

   nrn_sat_acc #(
      .PROD_W(PROD_W), .ACC_W(ACC_W)
   ) i_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .bias  (bias),
      .add_en(accept),
      .term  (term),
      .acc   (acc)
   );

   nrn_act_lut #(
      .ACC_W(ACC_W), .LUT_AW(LUT_AW), .SLOPE(SLOPE), .OUT_W(NRN_OUT_W)
   ) i_lut (
      .acc(acc),
      .act(act_val)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= NS_IDLE;
         cnt     <= '0;
         done    <= 1'b0;
         act_out <= '0;
      end else begin
         done <= 1'b0;
         if (load) begin
            state <= NS_ACCUM;
            cnt   <= '0;
         end else begin
            unique case (state)
               NS_ACCUM: begin
                  if (accept) begin
                     cnt <= cnt + 1'b1;
                     if (cnt == IDX_W'(N_CONN - 1))
                        state <= NS_FINISH;
                  end
               end
               NS_FINISH: begin
                  done    <= 1'b1;
                  act_out <= act_val;
                  state   <= NS_IDLE;
               end
               default: state <= NS_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/nrn_checker.sv
module nrn_checker #(
   parameter int N_CONN = 5,
   parameter int IDX_W  = 3,
   parameter int ACC_W  = 12,
   parameter int OUT_W  = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             load,
   input logic             done,
   input logic [OUT_W-1:0] act_out,
   input logic             accum,
   input logic [IDX_W-1:0] cnt,
   input logic [ACC_W-1:0] acc
);
   p_restart_on_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == '0 && accum && !done));

   p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_after_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(cnt) == IDX_W'(N_CONN) && !$past(load)));

   p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= IDX_W'(N_CONN));

   p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(act_out));

   p_idle_acc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!accum && !load) |=> $stable(acc));

endmodule

bind serial_shift_neuron nrn_checker #(
   .N_CONN(N_CONN), .IDX_W(IDX_W), .ACC_W(ACC_W), .OUT_W(neuron_pkg::NRN_OUT_W)
) i_nrn_checker (
   .clk    (clk),
   .rst_n  (rst_n),
   .load   (load),
   .done   (done),
   .act_out(act_out),
   .accum  (accum),
   .cnt    (cnt),
   .acc    (acc)
);

// File: tb/test_serial_shift_neuron.sv
module test_serial_shift_neuron;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       load;
   logic [11:0] bias;
   logic       in_valid;
   logic [7:0] in_data;
   logic       done;
   logic [7:0] act_out;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 0;
   int xv[5];

   // R3 default table: connection 0..4 -> enable, negate, shift
   int wen[5] = '{1, 1, 1, 1, 0};
   int wneg[5] = '{0, 1, 0, 1, 0};
   int wsh[5] = '{1, 0, 3, 2, 0};

   always #5 clk = ~clk;

   serial_shift_neuron i_serial_shift_neuron (
      .clk(clk), .rst_n(rst_n), .load(load), .bias(bias),
      .in_valid(in_valid), .in_data(in_data), .done(done), .act_out(act_out)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int clamp(input int v, input int lo, input int hi);
      if (v < lo) return lo;
      if (v > hi) return hi;
      return v;
   endfunction

   function automatic int term_of(input int k, input int x);
      int v;
      if (wen[k] == 0) return 0;
      v = x >>> wsh[k];
      return (wneg[k] != 0) ? -v : v;
   endfunction

   function automatic int act_of(input int s);
      return clamp(128 + 4 * (s >>> 6), 0, 255);
   endfunction

   function automatic int model(input int b);
      int a;
      a = b;
      for (int k = 0; k < 5; k++)
         a = clamp(a + term_of(k, xv[k]), -2048, 2047);
      return act_of(a);
   endfunction

   task automatic run_case(input string req, input int b, input int gap, input bit overlap);
      int exp;
      exp = model(b);
      @(negedge clk);
      load = 1'b1;
      bias = 12'(b);
      if (overlap) begin
         in_valid = 1'b1;
         in_data  = 8'd99;
      end
      @(negedge clk);
      load = 1'b0;
      in_valid = 1'b0;
      for (int i = 0; i < 5; i++) begin
         repeat (gap) begin
            in_data = 8'hA5;
            @(negedge clk);
         end
         in_valid = 1'b1;
         in_data  = 8'(xv[i]);
         @(negedge clk);
         in_valid = 1'b0;
      end
      check("R6 done low right after last input", int'(done), 0);
      @(negedge clk);
      check("R6 done pulse", int'(done), 1);
      check(req, int'(act_out), exp);
      @(negedge clk);
      check("R6 done single cycle", int'(done), 0);
      check("R8 output held", int'(act_out), exp);
   endtask

   task automatic idle_noise(input int cycles);
      int held;
      held = int'(act_out);
      for (int i = 0; i < cycles; i++) begin
         in_valid = 1'b1;
         in_data  = 8'(i * 37 + 5);
         @(negedge clk);
         check("R10 no done when idle", int'(done), 0);
         check("R10 output unchanged when idle", int'(act_out), held);
      end
      in_valid = 1'b0;
   endtask

   initial begin
      int unsigned st;
      rst_n = 1'b0; load = 1'b0; bias = '0; in_valid = 1'b0; in_data = '0;
      repeat (3) @(negedge clk);
      check("R1 done in reset", int'(done), 0);
      check("R1 out in reset", int'(act_out), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 done after reset", int'(done), 0);
      check("R1 out after reset", int'(act_out), 0);

      idle_noise(4);

      // R2: bias alone
      for (int b = -2048; b < 2048; b += 61) begin
         for (int k = 0; k < 5; k++) xv[k] = 0;
         run_case("R2 bias only", b, 0, 0);
      end

      // R3: every input value on every connection
      for (int k = 0; k < 5; k++)
         for (int x = -128; x < 128; x++) begin
            for (int j = 0; j < 5; j++) xv[j] = 0;
            xv[k] = x;
            run_case("R3 weight code", ((((x * 37 + k * 13) % 128) + 128) % 128) - 64, 0, 0);
         end

      // R4: floor shift, bias stepped across one bucket
      for (int k = 0; k < 4; k++)
         for (int xi = 0; xi < 8; xi++) begin
            int xs[8] = '{-128, -127, -9, -7, -1, 1, 9, 127};
            for (int b = 0; b < 64; b++) begin
               for (int j = 0; j < 5; j++) xv[j] = 0;
               xv[k] = xs[xi];
               run_case("R4 arithmetic shift", b, 0, 0);
            end
         end

      // R5: mixed patterns with valid gaps
      st = 32'h1234_5678;
      for (int n = 0; n < 300; n++) begin
         for (int j = 0; j < 5; j++) begin
            st = st * 1103515245 + 12345;
            xv[j] = int'((st >> 16) & 255) - 128;
         end
         run_case("R5 connection order", (n * 97 % 1024) - 512, n % 3, 0);
      end

      // R7: saturation at both limits
      xv = '{127, 127, -128, 0, 0};
      run_case("R7 positive saturation", 2047, 0, 0);
      xv = '{-128, 127, 127, 0, 0};
      run_case("R7 negative saturation", -2048, 0, 0);
      for (int b = 1900; b < 2048; b += 7) begin
         xv = '{127, 120, -100, -128, 55};
         run_case("R7 near top", b, 1, 0);
         xv = '{-128, -120, 100, 127, 55};
         run_case("R7 near bottom", -b, 1, 0);
      end

      // R9: restart mid pass
      @(negedge clk);
      load = 1'b1; bias = 12'd1500;
      @(negedge clk);
      load = 1'b0;
      for (int i = 0; i < 3; i++) begin
         in_valid = 1'b1; in_data = 8'd100;
         @(negedge clk);
         check("R9 no done during partial pass", int'(done), 0);
      end
      in_valid = 1'b0;
      xv = '{10, -20, 30, -40, 50};
      run_case("R9 restart", -300, 0, 0);

      // R11: load and valid together
      xv = '{64, 64, 64, 64, 64};
      run_case("R11 load wins over valid", 0, 0, 1);
      xv = '{-100, 90, -80, 70, -60};
      run_case("R11 load wins over valid", 700, 2, 1);

      idle_noise(6);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      finished = 1;
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule